// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave

This block models the memory side of a three-wire serial EEPROM link: a chip select, a shift clock, a data input and a data output. The shift clock is sampled on the system clock and its rising edges are detected there. Each frame opens with a start bit and a two-bit opcode, then carries an address field, and write frames also carry a data field. The block serves single and streaming reads, word writes, word erases, whole-array fills and erases, and the commands that enable and disable programming. All of these act on an internal store that holds 512 bytes. The store is seen as 512 x 8 when `org16_i` is low and as 256 x 16 when it is high.

A programming operation starts when the select line drops after a complete frame. A cycle counter stands in for the self-timed programming delay. If the select line is raised while that time runs, the data output reports whether the operation is still busy or has finished. After reset, programming is locked until an enable command is received.

Top module: `mw_eeprom`

## Requirements
- R1: A frame begins at the first SK rising edge, with CS high and no busy cycle running, on which DI is 1. Zeros clocked in before that edge are ignored. The next two bits form the opcode: 10 read, 01 write, 11 erase, 00 special.
- R2: A read outputs one 0 bit on DO after the last address bit. After that it outputs the word MSB first, one bit for each later SK rising edge. The address is 9 bits in x8 mode and 8 bits in x16 mode, MSB first.
- R3: While CS stays high after a read word, the address increments and the next word follows at once, with no dummy bit. After the last location (511 in x8, 255 in x16) the address wraps to 0.
- R4: After reset every location reads all ones and programming is locked. Write, erase, erase-all and write-all have no effect while locked, and no programming cycle starts. Once enabled, programming stays allowed until a disable command or reset.
- R5: A write stores the 8 or 16 data bits that follow the address, MSB first. No prior erase is needed. In x16 mode, word a holds byte location 2a as its upper half and 2a+1 as its lower half.
- R6: An erase sets every bit of the addressed location to 1.
- R7: Erase-all sets every location to ones. Write-all stores its data word in every location. In x16 mode this puts the upper data byte in even byte locations and the lower data byte in odd ones.
- R8: Programming starts when CS falls after a complete frame and lasts PROG_CYCLES system clocks. While CS is high after that, DO drives 0 during busy and 1 once done. DO is not driven (dout_oe_o low) while CS is low.
- R9: A frame sent while a programming cycle is running is ignored as a whole.
- R10: For opcode 00, the two most significant address bits choose the command: 11 enable, 00 disable, 10 erase-all, 01 write-all (followed by data). The other address bits are don't-care but must be clocked in.
- R11: A frame cut short by CS falling before its last bit has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cs_i | input | 1 | Chip select, active high |
| sck_i | input | 1 | Serial shift clock |
| din_i | input | 1 | Serial data in |
| org16_i | input | 1 | 1 selects 16-bit words, 0 selects 8-bit words |
| dout_o | output | 1 | Serial data out / ready-busy status |
| dout_oe_o | output | 1 | Output enable for dout_o |

## Verification
A programming cycle and a new frame can overlap. While the timer counts, the raised select line brings the status flag onto DO in the same cycles in which start and data bits arrive. The bench provokes this by sending a second write straight after the first, with no wait in between. It judges the result by three things: DO must read busy when polled, the first target must hold its new value, and the second target must keep its old one. A second overlap checks that the last bit of a read word and the address increment fall in the same shift-clock edge at the top of the array.

// File: rtl/mw_eeprom_pkg.sv
package mw_eeprom_pkg;
    typedef enum logic [2:0] {
        S_IDLE, S_OPC, S_ADR, S_DAT, S_RD, S_DONE
    } ee_st_e;

    typedef enum logic [2:0] {
        P_NONE, P_WR, P_ER, P_WRALL, P_ERALL
    } ee_pend_e;

    localparam logic [1:0] OP_SPEC  = 2'b00;
    localparam logic [1:0] OP_WRITE = 2'b01;
    localparam logic [1:0] OP_READ  = 2'b10;
    localparam logic [1:0] OP_ERASE = 2'b11;

    localparam logic [1:0] SUB_LOCK  = 2'b00;
    localparam logic [1:0] SUB_FILL  = 2'b01;
    localparam logic [1:0] SUB_CLEAR = 2'b10;
    localparam logic [1:0] SUB_OPEN  = 2'b11;
endpackage

// File: rtl/ee_sync.sv
module ee_sync #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] a_i,
    output logic [N-1:0] s_o
);
    logic [N-1:0] m_q, s_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_q <= '0;
            s_q <= '0;
        end else begin
            m_q <= a_i;
            s_q <= m_q;
        end
    end

    assign s_o = s_q;
endmodule

// File: rtl/ee_prog_timer.sv
module ee_prog_timer #(
    parameter int CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start_i)
            cnt_d = CW'(CYCLES);
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/ee_array.sv
module ee_array #(
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              org16_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [15:0]       rd_word_o,
    input  logic              we_i,
    input  logic              we_all_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [15:0]       wr_word_i
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] mem [DEPTH];

    logic [ADDR_W-1:0] rd_hi, rd_lo, wr_hi, wr_lo;
    assign rd_hi = {rd_addr_i[ADDR_W-2:0], 1'b0};
    assign rd_lo = {rd_addr_i[ADDR_W-2:0], 1'b1};
    assign wr_hi = {wr_addr_i[ADDR_W-2:0], 1'b0};
    assign wr_lo = {wr_addr_i[ADDR_W-2:0], 1'b1};

    always_comb begin
        if (org16_i) rd_word_o = {mem[rd_hi], mem[rd_lo]};
        else         rd_word_o = {8'h00, mem[rd_addr_i]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        end else if (we_i) begin
            if (we_all_i) begin
                for (int i = 0; i < DEPTH; i++)
                    mem[i] <= (org16_i && (i % 2 == 0)) ? wr_word_i[15:8] : wr_word_i[7:0];
            end else if (org16_i) begin
                mem[wr_hi] <= wr_word_i[15:8];
                mem[wr_lo] <= wr_word_i[7:0];
            end else begin
                mem[wr_addr_i] <= wr_word_i[7:0];
            end
        end
    end
endmodule

// File: rtl/mw_eeprom.sv
module mw_eeprom
    import mw_eeprom_pkg::*;
#(
    parameter int ADDR_W      = 9,
    parameter int PROG_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_i,
    input  logic sck_i,
    input  logic din_i,
    input  logic org16_i,
    output logic dout_o,
    output logic dout_oe_o
);
    localparam int CNT_W = 5;

    typedef struct packed {
        ee_st_e            st;
        logic [1:0]        op;
        logic [ADDR_W-1:0] adr;
        logic [15:0]       dat;
        logic [15:0]       sh;
        logic [CNT_W-1:0]  cnt;
        ee_pend_e          pend;
        logic              wen;
        logic              stat;
        logic              dout;
        logic              sck_p;
        logic              cs_p;
    } regs_t;

    regs_t d, q;

    logic [2:0] sync_w;
    logic cs_s, sck_s, din_s;
    logic busy;
    logic [15:0] rd_word;
    logic [ADDR_W-1:0] rd_addr_c;
    logic arr_we, arr_all;
    logic [15:0] arr_wdata;
    logic rd_active, wen_on;

    ee_sync #(.N(3)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .a_i  ({cs_i, sck_i, din_i}),
        .s_o  (sync_w)
    );
    assign {cs_s, sck_s, din_s} = sync_w;

    ee_prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .start_i(arr_we),
        .busy_o (busy)
    );

    ee_array #(.ADDR_W(ADDR_W)) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .org16_i  (org16_i),
        .rd_addr_i(rd_addr_c),
        .rd_word_o(rd_word),
        .we_i     (arr_we),
        .we_all_i (arr_all),
        .wr_addr_i(q.adr),
        .wr_word_i(arr_wdata)
    );

    // derived per-organisation quantities
    logic              sck_rise, cs_fall;
    logic [CNT_W-1:0]  a_last, w_last;
    logic [ADDR_W-1:0] a_mask, adr_n, adr_inc;
    logic [1:0]        sub;

    assign sck_rise = sck_s & ~q.sck_p;
    assign cs_fall  = q.cs_p & ~cs_s;
    assign a_last   = org16_i ? CNT_W'(ADDR_W - 2) : CNT_W'(ADDR_W - 1);
    assign w_last   = org16_i ? CNT_W'(15) : CNT_W'(7);
    assign a_mask   = org16_i ? {1'b0, {(ADDR_W-1){1'b1}}} : {ADDR_W{1'b1}};
    assign adr_n    = {q.adr[ADDR_W-2:0], din_s};
    assign adr_inc  = (q.adr + 1'b1) & a_mask;
    assign sub      = org16_i ? adr_n[ADDR_W-2 -: 2] : adr_n[ADDR_W-1 -: 2];
    assign rd_addr_c = (q.st == S_ADR) ? adr_n : adr_inc;

    function automatic logic [15:0] align(input logic [15:0] w, input logic o16);
        return o16 ? w : {w[7:0], 8'h00};
    endfunction

    always_comb begin
        d         = q;
        d.sck_p   = sck_s;
        d.cs_p    = cs_s;
        arr_we    = 1'b0;
        arr_all   = 1'b0;
        arr_wdata = 16'hFFFF;

        if (!cs_s) begin
            d.st   = S_IDLE;
            d.pend = P_NONE;
            if (cs_fall && q.st == S_DONE && q.pend != P_NONE && q.wen && !busy) begin
                arr_we    = 1'b1;
                arr_all   = (q.pend == P_WRALL) || (q.pend == P_ERALL);
                arr_wdata = ((q.pend == P_WR) || (q.pend == P_WRALL)) ? q.dat : 16'hFFFF;
                d.stat    = 1'b1;
            end
        end else if (sck_rise) begin
            unique case (q.st)
                S_IDLE: begin
                    if (!busy && din_s) begin
                        d.st   = S_OPC;
                        d.cnt  = '0;
                        d.adr  = '0;
                        d.stat = 1'b0;
                    end
                end
                S_OPC: begin
                    d.op  = {q.op[0], din_s};
                    d.cnt = q.cnt + 1'b1;
                    if (q.cnt == CNT_W'(1)) begin
                        d.st  = S_ADR;
                        d.cnt = '0;
                    end
                end
                S_ADR: begin
                    d.adr = adr_n;
                    d.cnt = q.cnt + 1'b1;
                    if (q.cnt == a_last) begin
                        d.cnt = '0;
                        d.st  = S_DONE;
                        unique case (q.op)
                            OP_READ: begin
                                d.st   = S_RD;
                                d.dout = 1'b0;
                                d.sh   = align(rd_word, org16_i);
                            end
                            OP_WRITE: begin
                                d.st   = S_DAT;
                                d.pend = P_WR;
                            end
                            OP_ERASE: d.pend = P_ER;
                            default: begin
                                unique case (sub)
                                    SUB_OPEN:  d.wen  = 1'b1;
                                    SUB_LOCK:  d.wen  = 1'b0;
                                    SUB_CLEAR: d.pend = P_ERALL;
                                    default: begin
                                        d.st   = S_DAT;
                                        d.pend = P_WRALL;
                                    end
                                endcase
                            end
                        endcase
                    end
                end
                S_DAT: begin
                    d.dat = {q.dat[14:0], din_s};
                    d.cnt = q.cnt + 1'b1;
                    if (q.cnt == w_last) d.st = S_DONE;
                end
                S_RD: begin
                    d.dout = q.sh[15];
                    d.sh   = {q.sh[14:0], 1'b0};
                    d.cnt  = q.cnt + 1'b1;
                    if (q.cnt == w_last) begin
                        d.cnt = '0;
                        d.adr = adr_inc;
                        d.sh  = align(rd_word, org16_i);
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= S_IDLE;
            q.pend <= P_NONE;
        end else begin
            q <= d;
        end
    end

    assign rd_active = (q.st == S_RD);
    assign wen_on    = q.wen;
    assign dout_oe_o = cs_s & (rd_active | ((q.st == S_IDLE) & q.stat));
    assign dout_o    = rd_active ? q.dout : ~busy;
endmodule

// File: rtl/mw_eeprom_chk.sv
module mw_eeprom_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_i,
    input logic dout_o,
    input logic dout_oe_o,
    input logic busy,
    input logic arr_we,
    input logic wen_on,
    input logic rd_active
);
    // R4
    locked_no_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> wen_on);

    // R9
    idle_timer_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> !busy);

    // R8
    busy_follows_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |=> busy);

    // R8
    quiet_when_deselected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cs_i, 2) |-> !dout_oe_o);

    // R2
    dummy_zero_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_active) |-> !dout_o);
endmodule

bind mw_eeprom mw_eeprom_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_i     (cs_i),
    .dout_o   (dout_o),
    .dout_oe_o(dout_oe_o),
    .busy     (busy),
    .arr_we   (arr_we),
    .wen_on   (wen_on),
    .rd_active(rd_active)
);

// File: tb/mw_eeprom_test.sv
module mw_eeprom_test;
    localparam int PROG = 2000;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cs = 1'b0, sck = 1'b0, din = 1'b0, org = 1'b0;
    logic dout, dout_oe;

    mw_eeprom #(.ADDR_W(9), .PROG_CYCLES(PROG)) uut (
        .clk(clk), .rst_n(rst_n), .cs_i(cs), .sck_i(sck), .din_i(din),
        .org16_i(org), .dout_o(dout), .dout_oe_o(dout_oe)
    );

    always #5 clk = ~clk;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;
    logic [7:0] ref_mem [512];
    bit wen_m = 0;
    int cs_low_cnt = 0;

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // per-clock comparison: DO must be released while CS is low (R8)
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (cs) cs_low_cnt = 0; else cs_low_cnt++;
            if (cs_low_cnt >= 3) chk(dout_oe == 1'b0, "R8 oe while CS low", 32'(dout_oe), 0);
        end
    end

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic send_bit(logic b);
        din = b; tick(8); sck = 1'b1; tick(8); sck = 1'b0;
    endtask

    task automatic cs_up();   cs = 1'b1; tick(4); endtask
    task automatic cs_down(); sck = 1'b0; din = 1'b0; cs = 1'b0; tick(8); endtask

    function automatic int abits(); return org ? 8 : 9; endfunction
    function automatic int wbits(); return org ? 16 : 8; endfunction

    task automatic hdr(logic [1:0] op, int addr);
        send_bit(1'b1); send_bit(op[1]); send_bit(op[0]);
        for (int i = abits() - 1; i >= 0; i--) send_bit(1'((addr >> i) & 1));
    endtask

    task automatic data_bits(logic [15:0] v);
        for (int i = wbits() - 1; i >= 0; i--) send_bit(v[i]);
    endtask

    function automatic logic [15:0] ref_word(int a);
        if (org) return {ref_mem[2*a], ref_mem[2*a+1]};
        return {8'h00, ref_mem[a]};
    endfunction

    task automatic ref_put(int a, logic [15:0] v);
        if (org) begin ref_mem[2*a] = v[15:8]; ref_mem[2*a+1] = v[7:0]; end
        else ref_mem[a] = v[7:0];
    endtask

    task automatic ref_fill(logic [15:0] v);
        for (int i = 0; i < 512; i++)
            ref_mem[i] = (org && (i % 2 == 0)) ? v[15:8] : v[7:0];
    endtask

    task automatic wr(int a, logic [15:0] v);
        cs_up(); hdr(2'b01, a); data_bits(v); cs_down();
    endtask

    task automatic special(logic [1:0] sub);
        cs_up(); hdr(2'b00, int'(sub) << (abits() - 2));
    endtask

    task automatic wait_ready(bit expect_prog, string req);
        cs_up();
        if (expect_prog) begin
            chk(dout_oe && !dout, {req, " busy status"}, {dout_oe, dout}, 2'b10);
            for (int k = 0; k < PROG + 100 && !dout; k++) tick(1);
            chk(dout_oe && dout, {req, " ready status"}, {dout_oe, dout}, 2'b11);
        end else begin
            chk(!dout_oe, {req, " no programming"}, 32'(dout_oe), 0);
        end
        cs_down();
    endtask

    task automatic rd(int a, int n, string req, bit lead = 0);
        logic [15:0] got;
        int p = a;
        int mask = org ? 255 : 511;
        cs_up();
        if (lead) begin send_bit(0); send_bit(0); end
        hdr(2'b10, a);
        chk(dout_oe && !dout, "R2 dummy bit", {dout_oe, dout}, 2'b10);
        for (int k = 0; k < n; k++) begin
            got = '0;
            for (int b = 0; b < wbits(); b++) begin
                send_bit(1'b0);
                got = {got[14:0], dout};
            end
            chk(got == ref_word(p), req, got, ref_word(p));
            p = (p + 1) & mask;
        end
        cs_down();
    endtask

    initial begin
        for (int i = 0; i < 512; i++) ref_mem[i] = 8'hFF;
        tick(5);
        rst_n = 1'b1;
        tick(3);
        chk(!dout_oe, "R8 reset oe", 32'(dout_oe), 0);
        rd(5, 1, "R4 erased after reset");

        wr(3, 16'h5A); wait_ready(0, "R4 locked write");
        rd(3, 1, "R4 locked write has no effect");

        special(2'b11); cs_down(); wen_m = 1;
        wr(3, 16'h5A); ref_put(3, 16'h5A); wait_ready(1, "R8 write");
        rd(3, 1, "R5 x8 write");

        wr(511, 16'hC3); ref_put(511, 16'hC3); wait_ready(1, "R8");
        wr(0, 16'h11);   ref_put(0, 16'h11);   wait_ready(1, "R8");
        wr(1, 16'h22);   ref_put(1, 16'h22);   wait_ready(1, "R8");
        rd(511, 3, "R3 x8 sequential wrap");

        cs_up(); hdr(2'b11, 3); cs_down(); ref_put(3, 16'hFFFF);
        wait_ready(1, "R6 erase");
        rd(3, 1, "R6 erased word");

        org = 1'b1;
        wr(16, 16'hBEEF); ref_put(16, 16'hBEEF); wait_ready(1, "R8 x16");
        rd(16, 1, "R5 x16 write");
        org = 1'b0;
        rd(32, 2, "R5 x16 byte mapping");

        wr(7, 16'h77); ref_put(7, 16'h77);
        wr(8, 16'h88);
        wait_ready(1, "R9 overlap");
        rd(7, 2, "R9 frame during busy ignored");

        cs_up(); send_bit(1); send_bit(0); send_bit(1);
        for (int i = 0; i < 5; i++) send_bit(0);
        cs_down();
        wait_ready(0, "R11 aborted frame");
        rd(9, 1, "R11 aborted write no effect");

        rd(7, 1, "R1 leading zeros ignored", 1);

        special(2'b01); data_bits(16'hA5); cs_down(); ref_fill(16'hA5);
        wait_ready(1, "R7 write-all");
        rd(510, 3, "R7 write-all x8");
        special(2'b10); cs_down(); ref_fill(16'hFFFF);
        wait_ready(1, "R10 erase-all");
        rd(100, 1, "R7 erase-all");

        org = 1'b1;
        special(2'b01); data_bits(16'h1234); cs_down(); ref_fill(16'h1234);
        wait_ready(1, "R10 write-all x16");
        wr(255, 16'hA1B2); ref_put(255, 16'hA1B2); wait_ready(1, "R8 x16");
        rd(255, 2, "R3 x16 sequential wrap");

        special(2'b00); cs_down(); wen_m = 0;
        wr(2, 16'h5555); wait_ready(0, "R10 disable");
        rd(2, 1, "R4 disabled again");

        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            chk(1'b0, "watchdog", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule